// File: doc/BRIEF.md
# Deferred read responder

This block sits on the initiator side of a bridge and answers reads as deferred transactions. No read completes on its first attempt. When a new read arrives, the block latches the address, command and address parity during the address phase. It takes the byte enables in the data phase. It then pushes the request as one entry toward the request queue and ends the cycle with a retry. The initiator keeps repeating the read. The block releases data only when three conditions hold together: the repeat is identical to the stored request, return data for it is at the head of the return-data queue, and the ordering flag says the posted writes ahead of it have drained. In every other case the block retries again.

The bus is a simplified parallel one, with separate strobes for the data transfer and for the retry:

- An address phase is a one-cycle `bus_frame` pulse.
- The data phase begins in the first cycle in which `bus_irdy` is high.
- The target answers in the cycle after that, with either `bus_stop` (retry) or a burst of `bus_trdy` words.

Only one request is held at a time. The held entry is freed after the word that the return queue marks as the last one.

Top module: `dr_read_target`

## Requirements
- R1: A read that arrives while no request is held, with `dtq_full` low, raises `dtq_push` for exactly one cycle: the data-phase cycle in which `bus_irdy` is first high. `dtq_addr`, `dtq_cmd` and `dtq_par` carry the values sampled with `bus_frame`, and `dtq_be` carries `bus_be` of that cycle. In the next cycle `bus_stop` is high and `bus_trdy` is low.
- R2: Byte enables are taken only in the cycle in which `bus_irdy` is high. Values on `bus_be` in earlier cycles of the same transaction, and values on `bus_addr` after the address phase, affect neither the pushed entry nor the match.
- R3: With no request held and `dtq_full` high, the read is retried and `dtq_push` stays low. No request is held afterwards, so a later read with `dtq_full` low pushes.
- R4: While a request is held, a read that differs from it in address, command or byte enables is retried, and `dtq_push` stays low.
- R5: A read that matches the held request is retried without a push in either of two cases: `rdq_valid` is low in its data-phase cycle, or `order_ok` is low in that cycle.
- R6: A matching read whose data-phase cycle sees `rdq_valid` and `order_ok` high gets a burst that starts the next cycle. In each burst cycle in which `rdq_valid` is high, `bus_trdy` is high, `bus_data` equals `rdq_data`, `bus_stop` is low, and `rdq_pop` equals `bus_irdy`. `bus_trdy` and `bus_stop` are never high together.
- R7: If `rdq_valid` is low in a burst cycle before the last word, that cycle shows `bus_stop` high with `bus_trdy` low, and the request stays held. A later matching repeat continues with the next word.
- R8: Once the word marked by `rdq_last` is popped, the held request is freed and the block returns to idle. The next read with `dtq_full` low pushes a new entry.
- R9: During reset and in the cycle after it, `bus_trdy`, `bus_stop`, `dtq_push` and `rdq_pop` are low, and no request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame | input | 1 | Address-phase strobe, one cycle |
| bus_addr | input | AW | Read address, valid with `bus_frame` |
| bus_cmd | input | CW | Bus command, valid with `bus_frame` |
| bus_par | input | 1 | Address parity, valid with `bus_frame` |
| bus_irdy | input | 1 | Initiator ready |
| bus_be | input | BW | Byte enables, valid with `bus_irdy` |
| bus_trdy | output | 1 | Target ready, a data word is on `bus_data` |
| bus_stop | output | 1 | Retry or disconnect |
| bus_data | output | DW | Returned read data |
| dtq_full | input | 1 | Request queue cannot accept an entry |
| dtq_push | output | 1 | Push one request entry |
| dtq_addr | output | AW | Entry address |
| dtq_cmd | output | CW | Entry command |
| dtq_be | output | BW | Entry byte enables |
| dtq_par | output | 1 | Entry address parity |
| rdq_valid | input | 1 | Return-data queue head is valid |
| rdq_data | input | DW | Return-data queue head word |
| rdq_last | input | 1 | Head word is the last of the completion |
| rdq_pop | output | 1 | Head word is consumed |
| order_ok | input | 1 | Posted writes ahead of the completion have drained |

## Verification
The assertions rely on the following input behaviour:

- `bus_frame` is pulsed only when the bus is idle.
- `bus_irdy` stays high for the whole of a burst.
- `rdq_data` and `rdq_last` describe the head entry of the held request only.

The bench drives one transaction at a time. It asserts `bus_irdy` only after the address phase and drops it after the block's answer. It presents return data only for the request it models as held, and it lets the amount of available data grow only between transactions. Every other input, including byte-enable garbage before `bus_irdy` and the state of the full and ordering flags, is chosen at random.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_BE = 2'd1,
    ST_RETRY   = 2'd2,
    ST_XFER    = 2'd3
  } dr_state_e;
endpackage

// File: rtl/dr_capture.sv
module dr_capture #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [CW-1:0] in_cmd,
  input  logic          in_par,
  output logic [AW-1:0] cap_addr,
  output logic [CW-1:0] cap_cmd,
  output logic          cap_par
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_cmd  <= '0;
      cap_par  <= 1'b0;
    end else if (load) begin
      cap_addr <= in_addr;
      cap_cmd  <= in_cmd;
      cap_par  <= in_par;
    end
  end
endmodule

// File: rtl/dr_entry.sv
module dr_entry #(
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_cmd,
  input  logic [BW-1:0] req_be,
  output logic          busy,
  output logic          hit
);
  logic [AW-1:0] held_addr;
  logic [CW-1:0] held_cmd;
  logic [BW-1:0] held_be;

  function automatic logic req_match(
    input logic [AW-1:0] a0, input logic [CW-1:0] c0, input logic [BW-1:0] b0,
    input logic [AW-1:0] a1, input logic [CW-1:0] c1, input logic [BW-1:0] b1);
    return (a0 == a1) && (c0 == c1) && (b0 == b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held_addr <= '0;
      held_cmd  <= '0;
      held_be   <= '0;
    end else if (set) begin
      busy      <= 1'b1;
      held_addr <= req_addr;
      held_cmd  <= req_cmd;
      held_be   <= req_be;
    end else if (clr) begin
      busy <= 1'b0;
    end
  end

  assign hit = busy && req_match(held_addr, held_cmd, held_be, req_addr, req_cmd, req_be);
endmodule

// File: rtl/dr_ctrl.sv
module dr_ctrl
  import dr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame,
  input  logic      irdy,
  input  logic      dtq_full,
  input  logic      order_ok,
  input  logic      rdq_valid,
  input  logic      rdq_last,
  input  logic      busy,
  input  logic      hit,
  output logic      load,
  output logic      push,
  output logic      clr,
  output logic      trdy,
  output logic      stop,
  output logic      pop,
  output logic      start_xfer,
  output dr_state_e state
);
  dr_state_e nxt;

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    push       = 1'b0;
    clr        = 1'b0;
    trdy       = 1'b0;
    stop       = 1'b0;
    pop        = 1'b0;
    start_xfer = 1'b0;
    case (state)
      ST_IDLE: begin
        if (frame) begin
          load = 1'b1;
          nxt  = ST_WAIT_BE;
        end
      end
      ST_WAIT_BE: begin
        if (irdy) begin
          if (!busy && !dtq_full) push = 1'b1;
          if (hit && rdq_valid && order_ok) begin
            start_xfer = 1'b1;
            nxt        = ST_XFER;
          end else begin
            nxt = ST_RETRY;
          end
        end
      end
      ST_RETRY: begin
        stop = 1'b1;
        nxt  = ST_IDLE;
      end
      ST_XFER: begin
        trdy = rdq_valid;
        stop = !rdq_valid;
        pop  = rdq_valid && irdy;
        if (!rdq_valid) begin
          nxt = ST_IDLE;
        end else if (pop && rdq_last) begin
          clr = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dr_read_target.sv
module dr_read_target #(
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int BW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_frame,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_cmd,
  input  logic          bus_par,
  input  logic          bus_irdy,
  input  logic [BW-1:0] bus_be,
  output logic          bus_trdy,
  output logic          bus_stop,
  output logic [DW-1:0] bus_data,
  input  logic          dtq_full,
  output logic          dtq_push,
  output logic [AW-1:0] dtq_addr,
  output logic [CW-1:0] dtq_cmd,
  output logic [BW-1:0] dtq_be,
  output logic          dtq_par,
  input  logic          rdq_valid,
  input  logic [DW-1:0] rdq_data,
  input  logic          rdq_last,
  output logic          rdq_pop,
  input  logic          order_ok
);
  import dr_pkg::*;

  logic          cap_load;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] cap_cmd;
  logic          cap_par;
  logic          entry_busy;
  logic          entry_hit;
  logic          entry_clr;
  logic          xfer_start;
  logic          last_pop;
  dr_state_e     state;

  dr_capture #(.AW(AW), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load),
    .in_addr(bus_addr), .in_cmd(bus_cmd), .in_par(bus_par),
    .cap_addr(cap_addr), .cap_cmd(cap_cmd), .cap_par(cap_par)
  );

  dr_entry #(.AW(AW), .CW(CW), .BW(BW)) u_entry (
    .clk(clk), .rst_n(rst_n), .set(dtq_push), .clr(entry_clr),
    .req_addr(cap_addr), .req_cmd(cap_cmd), .req_be(bus_be),
    .busy(entry_busy), .hit(entry_hit)
  );

  dr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame(bus_frame), .irdy(bus_irdy),
    .dtq_full(dtq_full), .order_ok(order_ok), .rdq_valid(rdq_valid),
    .rdq_last(rdq_last), .busy(entry_busy), .hit(entry_hit),
    .load(cap_load), .push(dtq_push), .clr(entry_clr), .trdy(bus_trdy),
    .stop(bus_stop), .pop(rdq_pop), .start_xfer(xfer_start), .state(state)
  );

  assign last_pop = rdq_pop && rdq_last;
  assign dtq_addr = cap_addr;
  assign dtq_cmd  = cap_cmd;
  assign dtq_be   = bus_be;
  assign dtq_par  = cap_par;
  assign bus_data = bus_trdy ? rdq_data : '0;
endmodule

// File: rtl/dr_read_target_chk.sv
module dr_read_target_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_irdy,
  input logic bus_trdy,
  input logic bus_stop,
  input logic dtq_full,
  input logic dtq_push,
  input logic rdq_valid,
  input logic rdq_pop,
  input logic order_ok,
  input logic entry_busy,
  input logic entry_hit,
  input logic xfer_start,
  input logic last_pop
);
  p_push_then_retry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dtq_push |=> (bus_stop && !bus_trdy));
  p_push_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dtq_push |-> !dtq_full);
  p_no_push_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dtq_push |-> !entry_busy);
  p_release_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (entry_hit && rdq_valid && order_ok));
  p_trdy_stop_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_trdy && bus_stop));
  p_pop_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdq_pop |-> (bus_trdy && bus_irdy));
  p_free_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_pop |=> !entry_busy);
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!bus_stop && !bus_trdy && !dtq_push && !rdq_pop && !entry_busy));
endmodule

bind dr_read_target dr_read_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_irdy(bus_irdy), .bus_trdy(bus_trdy),
  .bus_stop(bus_stop), .dtq_full(dtq_full), .dtq_push(dtq_push),
  .rdq_valid(rdq_valid), .rdq_pop(rdq_pop), .order_ok(order_ok),
  .entry_busy(entry_busy), .entry_hit(entry_hit), .xfer_start(xfer_start),
  .last_pop(last_pop)
);

// File: tb/dr_read_target_bench.sv
module dr_read_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, CW = 4, BW = 4, DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_frame = 1'b0, bus_par = 1'b0, bus_irdy = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_cmd = '0;
  logic [BW-1:0] bus_be = '0;
  logic          bus_trdy, bus_stop, dtq_push, dtq_par, rdq_pop;
  logic [DW-1:0] bus_data;
  logic [AW-1:0] dtq_addr;
  logic [CW-1:0] dtq_cmd;
  logic [BW-1:0] dtq_be;
  logic          dtq_full = 1'b0, rdq_valid = 1'b0, rdq_last = 1'b0, order_ok = 1'b1;
  logic [DW-1:0] rdq_data = '0;

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;

  bit            m_busy = 1'b0;
  logic [AW-1:0] m_addr;
  logic [CW-1:0] m_cmd;
  logic [BW-1:0] m_be;
  int            m_len, m_ptr, m_avail;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_read_target #(.AW(AW), .CW(CW), .BW(BW), .DW(DW)) u_dr_read_target (.*);

  function automatic logic [DW-1:0] word_val(logic [AW-1:0] a, int idx);
    return {a, 16'h0} ^ (32'h0101_0101 * (idx + 1));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_rdq();
    rdq_valid = m_busy && (m_ptr < m_avail);
    rdq_data  = word_val(m_addr, m_ptr);
    rdq_last  = (m_ptr == m_len - 1);
  endtask

  task automatic run_read(logic [AW-1:0] a, logic [CW-1:0] c, logic [BW-1:0] b,
                          bit p, int waits, bit full, bit ord);
    bit exp_push, exp_xfer, hit;
    @(negedge clk);
    bus_frame = 1'b1; bus_addr = a; bus_cmd = c; bus_par = p;
    bus_irdy = 1'b0; bus_be = BW'($urandom); dtq_full = full; order_ok = ord;
    drive_rdq();
    #1 chk("R1 no push in address phase", dtq_push, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      bus_frame = 1'b0; bus_addr = AW'($urandom); bus_be = BW'($urandom);
      #1 chk("R2 no push before irdy", dtq_push, 0);
    end
    @(negedge clk);
    bus_frame = 1'b0; bus_addr = AW'($urandom); bus_irdy = 1'b1; bus_be = b;
    drive_rdq();
    hit      = m_busy && (a == m_addr) && (c == m_cmd) && (b == m_be);
    exp_push = !m_busy && !full;
    exp_xfer = hit && (m_ptr < m_avail) && ord;
    #1;
    chk(full ? "R3 push with full" : (m_busy ? "R4/R5 push while held" : "R1 push"),
        dtq_push, exp_push);
    if (exp_push)
      chk("R1 R2 entry fields", {dtq_addr, dtq_cmd, dtq_be, dtq_par}, {a, c, b, p});
    if (exp_push) begin
      m_busy = 1'b1; m_addr = a; m_cmd = c; m_be = b;
      m_len = 1 + int'($urandom % 4); m_ptr = 0; m_avail = 0;
    end
    if (!exp_xfer) begin
      @(negedge clk);
      drive_rdq();
      #1;
      chk("R1 R3 R4 R5 retry stop", bus_stop, 1);
      chk("R1 R3 R4 R5 retry trdy", bus_trdy, 0);
    end else begin
      forever begin
        @(negedge clk);
        drive_rdq();
        #1;
        if (rdq_valid) begin
          chk("R6 burst trdy", {bus_trdy, bus_stop, rdq_pop}, 3'b101);
          chk("R6 burst data", bus_data, word_val(m_addr, m_ptr));
          m_ptr++;
          if (m_ptr == m_len) begin
            m_busy = 1'b0;
            break;
          end
        end else begin
          chk("R7 disconnect", {bus_trdy, bus_stop, rdq_pop}, 3'b010);
          break;
        end
      end
    end
    @(negedge clk);
    bus_irdy = 1'b0; rdq_valid = 1'b0;
    #1 chk("R8 R9 idle quiet", {bus_trdy, bus_stop, dtq_push, rdq_pop}, 4'b0);
  endtask

  task automatic grow(int n);
    if (m_busy) begin
      m_avail = m_avail + n;
      if (m_avail > m_len) m_avail = m_len;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3 + 2);
    chk("R9 reset outputs", {bus_trdy, bus_stop, dtq_push, rdq_pop}, 4'b0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R9 after reset", {bus_trdy, bus_stop, dtq_push, rdq_pop}, 4'b0);

    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 2, 1'b1, 1'b1); // R3 full: no push
    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 2, 1'b0, 1'b1); // R1/R2 push
    run_read(16'h2000, 4'h6, 4'h3, 1'b0, 0, 1'b0, 1'b1); // R4 addr mismatch
    run_read(16'h1000, 4'hC, 4'h3, 1'b1, 0, 1'b0, 1'b1); // R4 cmd mismatch
    run_read(16'h1000, 4'h6, 4'hF, 1'b1, 0, 1'b0, 1'b1); // R4 be mismatch
    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 1, 1'b0, 1'b1); // R5 not ready
    m_len = 3; grow(3);
    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 0, 1'b0, 1'b0); // R5 order blocked
    m_avail = 1;
    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 0, 1'b0, 1'b1); // R7 partial
    chk("R7 entry still held", m_busy, 1);
    grow(2);
    run_read(16'h1000, 4'h6, 4'h3, 1'b1, 0, 1'b0, 1'b1); // R6/R8 rest
    run_read(16'h3000, 4'h6, 4'h1, 1'b0, 0, 1'b0, 1'b1); // R8 new push

    for (int it = 0; it < 300; it++) begin
      logic [AW-1:0] a;
      logic [CW-1:0] c;
      logic [BW-1:0] b;
      grow(int'($urandom % 3));
      if (m_busy && ($urandom % 3 != 0)) begin
        a = m_addr; c = m_cmd; b = m_be;
      end else begin
        a = 16'h1000 + 16'(($urandom % 3) * 4);
        c = ($urandom % 2) ? 4'h6 : 4'hC;
        b = ($urandom % 2) ? 4'hF : 4'h0;
      end
      run_read(a, c, b, 1'($urandom), int'($urandom % 3),
               ($urandom % 5) == 0, ($urandom % 4) != 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule